// File: doc/BRIEF.md
# Lookahead Dual-Rail Precharge Pipeline

This block is a cycle-level, synthesizable model of a linear chain of dynamic-logic stages. The stages carry dual-rail data and alternate between precharge and evaluation. In precharge a stage's outputs are reset to a spacer, with both rails of every bit low. In evaluation the stage captures and holds one data token. Each stage is steered by two control lines. The first comes from its immediate successor and says "I have completed evaluation of your token". The second comes from the stage two places downstream and says "I hold a token". Because the second line can release evaluation before the successor has finished precharging, a stage's handshake cycle shrinks from six events to four. One clock edge models one asynchronous event.

The input side is a four-phase dual-rail channel with an acknowledge back to the producer. The output side is a dual-rail channel that the environment acknowledges. The last stage treats the environment acknowledge as its successor's completion signal and a one-event-delayed copy of it as its two-ahead signal. A bit whose two rails are both high is illegal. Such a bit is flagged and is never accepted or emitted.

Top module: `lp_pipe`

## Requirements
- R1: During and after reset every stage holds a spacer: out_t and out_f are all zero, in_ack is 0 and err is 0.
- R2: A stage precharges, and shows a spacer after the next event, exactly when its successor-completion line is 1 and its two-ahead line is 0. In every other case it evaluates. A token on the output therefore becomes a spacer one cycle after out_ack rises.
- R3: A stage's successor-completion line is 1 when it holds a token that the next stage has already copied. Its two-ahead line is 1 when the stage two places on holds a token. For the last stage these lines are out_ack and out_ack delayed by one cycle. For the stage before it, the two-ahead line is out_ack. A token that waits in the stage before last reaches the output one cycle after out_ack falls.
- R4: A stage that holds a token and is not told to precharge keeps that token unchanged, whatever arrives at its input.
- R5: Bit k is valid when exactly one of t[k], f[k] is high, and its value is t[k]. A word is a token only when all W bits are valid. A word with some bits still at spacer is not accepted.
- R6: in_ack rises on the cycle after stage 0 accepts a token. It stays high, and no further token is accepted, while the input remains non-spacer. It falls on the cycle after the input returns to spacer.
- R7: An input word that has any bit with both rails high sets err for the following cycle and is not accepted. out_t & out_f is never nonzero.
- R8: A token on the output stays there until out_ack rises. While out_ack is high and the output is a spacer, no new token is placed on the output.
- R9: A token presented to an empty pipeline with out_ack low appears on the output N cycles after it was presented.
- R10: Tokens leave in the order they entered, with no loss and no duplication, under arbitrary producer gaps and consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock, one asynchronous event per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_t | input | W | True rails of the input word |
| in_f | input | W | False rails of the input word |
| in_ack | output | 1 | Acknowledge to the producer (four-phase) |
| out_t | output | W | True rails of the output word |
| out_f | output | W | False rails of the output word |
| out_ack | input | 1 | Acknowledge from the consuming environment |
| err | output | 1 | High for one cycle after an input word with a both-rails-high bit |

## Verification
The hardest situation to reach from the ports is a token parked in the stage before last while the output holds an earlier token and out_ack is high. Only in that situation do both lookahead lines of the last two stages come from the acknowledge. To reach it, the bench stalls the output on a first token, feeds a second token through the full depth, and then raises and lowers out_ack by hand. It checks that the output goes to spacer, stays spacer while the acknowledge is high, and shows the second token exactly one cycle after the acknowledge falls. A table-driven stream with mixed producer gaps and consumer stalls then drives the lookahead paths in many different orders.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic {
        PH_PRECH = 1'b0,
        PH_EVAL  = 1'b1
    } lp_phase_e;

    // Merge of the two control lines: precharge only with successor done
    // and no token two places ahead; evaluate otherwise.
    function automatic lp_phase_e lp_merge(input logic succ_done, input logic ahead_full);
        return (succ_done && !ahead_full) ? PH_PRECH : PH_EVAL;
    endfunction

endpackage

// File: rtl/lp_rail_chk.sv
module lp_rail_chk #(
    parameter int W = 4
) (
    input  logic [W-1:0] t,
    input  logic [W-1:0] f,
    output logic         is_spacer,
    output logic         is_valid,
    output logic         is_illegal
);
    always_comb begin
        is_spacer  = ~|(t | f);
        is_illegal = |(t & f);
        is_valid   = &(t ^ f);
    end
endmodule

// File: rtl/lp_stage.sv
module lp_stage
    import lp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         succ_done,
    input  logic         ahead_full,
    input  logic         up_avail,
    input  logic         up_wave,
    input  logic [W-1:0] up_t,
    input  logic [W-1:0] up_f,
    input  logic         cap_ok,
    output logic         hold,
    output logic         wave,
    output logic         take,
    output logic [W-1:0] dt,
    output logic [W-1:0] df
);
    typedef struct packed {
        logic [W-1:0] t;
        logic [W-1:0] f;
        logic         wave;
    } stage_st_t;

    stage_st_t st_d, st_q;
    lp_phase_e ph;

    always_comb begin
        st_d = st_q;
        ph   = lp_merge(succ_done, ahead_full);
        hold = |(st_q.t | st_q.f);
        // capture a token not yet copied, only from a spacer state
        take = (ph == PH_EVAL) && !hold && up_avail && (up_wave != st_q.wave) && cap_ok;
        if (ph == PH_PRECH) begin
            st_d.t = '0;
            st_d.f = '0;
        end else if (take) begin
            st_d.t    = up_t;
            st_d.f    = up_f;
            st_d.wave = up_wave;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = st_q.wave;
    assign dt   = st_q.t;
    assign df   = st_q.f;

    assert_prech_spacer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (succ_done && !ahead_full) |=> (dt == '0 && df == '0));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !(succ_done && !ahead_full)) |=> ($stable(dt) && $stable(df)));

    assert_full_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ((dt ^ df) == '1 && (dt & df) == '0));
endmodule

// File: rtl/lp_in_port.sv
module lp_in_port #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_t,
    input  logic [W-1:0] in_f,
    input  logic         take0,
    output logic         in_avail,
    output logic         in_ack,
    output logic         err
);
    typedef struct packed {
        logic ack;
        logic err;
    } port_st_t;

    port_st_t st_d, st_q;
    logic sp, vld, bad;

    lp_rail_chk #(.W(W)) u_chk (
        .t(in_t), .f(in_f), .is_spacer(sp), .is_valid(vld), .is_illegal(bad)
    );

    always_comb begin
        st_d     = st_q;
        in_avail = vld && !st_q.ack;
        st_d.ack = st_q.ack ? !sp : take0;
        st_d.err = bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ack = st_q.ack;
    assign err    = st_q.err;

    assert_ack_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && !sp) |=> in_ack);

    assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && sp) |=> !in_ack);

    assert_bad_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> err);
endmodule

// File: rtl/lp_pipe.sv
module lp_pipe
    import lp_pkg::*;
#(
    parameter int W = 4,
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_t,
    input  logic [W-1:0] in_f,
    output logic         in_ack,
    output logic [W-1:0] out_t,
    output logic [W-1:0] out_f,
    input  logic         out_ack,
    output logic         err
);
    localparam int LAST = N - 1;

    typedef struct packed {
        logic ack_dly;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [W-1:0] s_t [N];
    logic [W-1:0] s_f [N];
    logic [N-1:0] s_hold, s_wave, s_pc, s_ev;
    logic         in_avail, take0;

    always_comb begin
        st_d         = st_q;
        st_d.ack_dly = out_ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lp_in_port #(.W(W)) u_in (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .take0(take0),
        .in_avail(in_avail), .in_ack(in_ack), .err(err)
    );

    for (genvar i = 0; i < N; i++) begin : g_stage
        logic         up_avail, up_wave, cap_ok, s_unused_take;
        logic [W-1:0] up_t, up_f;

        if (i == 0) begin : g_src_in
            assign up_avail = in_avail;
            assign up_wave  = ~s_wave[0];
            assign up_t     = in_t;
            assign up_f     = in_f;
        end else begin : g_src_prev
            assign up_avail = s_hold[i-1];
            assign up_wave  = s_wave[i-1];
            assign up_t     = s_t[i-1];
            assign up_f     = s_f[i-1];
        end

        if (i == LAST) begin : g_ctl_last
            assign s_pc[i] = out_ack;
            assign s_ev[i] = st_q.ack_dly;
            assign cap_ok  = !out_ack;
        end else if (i == LAST - 1) begin : g_ctl_prelast
            assign s_pc[i] = s_hold[i] && (s_wave[i+1] == s_wave[i]);
            assign s_ev[i] = out_ack;
            assign cap_ok  = 1'b1;
        end else begin : g_ctl_inner
            assign s_pc[i] = s_hold[i] && (s_wave[i+1] == s_wave[i]);
            assign s_ev[i] = s_hold[i+2];
            assign cap_ok  = 1'b1;
        end

        if (i == 0) begin : g_take0
            assign take0 = s_unused_take;
        end

        lp_stage #(.W(W)) u_st (
            .clk(clk), .rst_n(rst_n),
            .succ_done(s_pc[i]), .ahead_full(s_ev[i]),
            .up_avail(up_avail), .up_wave(up_wave), .up_t(up_t), .up_f(up_f),
            .cap_ok(cap_ok),
            .hold(s_hold[i]), .wave(s_wave[i]), .take(s_unused_take),
            .dt(s_t[i]), .df(s_f[i])
        );
    end

    assign out_t = s_t[LAST];
    assign out_f = s_f[LAST];

    assert_out_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_t & out_f) == '0);

    assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_ack) && s_hold[LAST]) |=> (out_t == '0 && out_f == '0));

    assert_idle_under_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ack && !s_hold[LAST]) |=> !s_hold[LAST]);

    assert_token_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ack && s_hold[LAST]) |=> (s_hold[LAST] && $stable(out_t)));
endmodule

// File: tb/sim_lp_pipe.sv
module sim_lp_pipe;
    localparam int W = 4;
    localparam int N = 10;
    localparam int NV = 16;

    // {value[11:8], producer gap[7:4], consumer stall[3:0]}
    localparam logic [11:0] TBL [NV] = '{
        12'hA00, 12'h501, 12'h003, 12'hF00, 12'h320, 12'hC05, 12'h712, 12'h800,
        12'h104, 12'hE30, 12'h602, 12'h900, 12'h211, 12'hD03, 12'h400, 12'hB21
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_t = '0;
    logic [W-1:0] in_f = '0;
    logic         in_ack;
    logic [W-1:0] out_t, out_f;
    logic         out_ack = 1'b0;
    logic         err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit rx_en = 1'b0;
    int rx_idx = 0;
    int stall  = 0;
    int lat;

    always #4 clk = ~clk;

    lp_pipe #(.W(W), .N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .in_ack(in_ack),
        .out_t(out_t), .out_f(out_f), .out_ack(out_ack), .err(err)
    );

    function automatic bit out_valid();
        return ((out_t ^ out_f) == '1) && ((out_t & out_f) == '0);
    endfunction

    function automatic bit out_spacer();
        return (out_t == '0) && (out_f == '0);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] v);
        in_t = v;
        in_f = ~v;
        do @(negedge clk); while (!in_ack);
        in_t = '0;
        in_f = '0;
        do @(negedge clk); while (in_ack);
    endtask

    // consumer for the table-driven stream
    initial begin
        forever begin
            @(negedge clk);
            if (rx_en) begin
                if (!out_ack && out_valid()) begin
                    if (stall > 0) begin
                        stall--;
                    end else begin
                        chk(rx_idx < NV && out_t == TBL[rx_idx & (NV-1)][11:8],
                            "R10 stream order", int'(out_t), int'(TBL[rx_idx & (NV-1)][11:8]));
                        stall = int'(TBL[rx_idx & (NV-1)][3:0]);
                        rx_idx++;
                        out_ack = 1'b1;
                    end
                end else if (out_ack && out_spacer()) begin
                    out_ack = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_spacer() && !in_ack && !err, "R1 during reset", int'({out_t, out_f}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_spacer() && !in_ack && !err, "R1 after reset", int'({out_t, out_f}), 0);

        // R9 / R6: latency through an empty pipeline
        in_t = 4'hA;
        in_f = ~4'hA;
        lat = -1;
        for (int k = 1; k <= N + 2; k++) begin
            @(negedge clk);
            if (k == 1) chk(in_ack == 1'b1, "R6 ack after accept", int'(in_ack), 1);
            if (lat < 0 && out_valid()) lat = k;
        end
        chk(lat == N, "R9 latency", lat, N);
        chk(out_t == 4'hA && out_f == 4'h5, "R5 output rails", int'({out_t, out_f}), 8'hA5);
        repeat (3) @(negedge clk);
        chk(in_ack == 1'b1, "R6 ack held while input valid", int'(in_ack), 1);
        in_t = '0;
        in_f = '0;
        @(negedge clk);
        chk(in_ack == 1'b0, "R6 ack drop after spacer", int'(in_ack), 0);

        // R4 / R8: output stalled, second token fed behind it
        send(4'h3);
        repeat (N + 2) @(negedge clk);
        chk(out_t == 4'hA && out_f == 4'h5, "R4 held token stable", int'(out_t), 4'hA);

        // R2 / R8 / R3: acknowledge sequence at the output end
        out_ack = 1'b1;
        @(negedge clk);
        chk(out_spacer(), "R2 spacer after ack rise", int'({out_t, out_f}), 0);
        @(negedge clk);
        chk(out_spacer(), "R8 spacer while ack high", int'({out_t, out_f}), 0);
        @(negedge clk);
        chk(out_spacer(), "R8 spacer while ack high 2", int'({out_t, out_f}), 0);
        out_ack = 1'b0;
        @(negedge clk);
        chk(out_valid() && out_t == 4'h3, "R3 next token after ack fall", int'(out_t), 4'h3);
        out_ack = 1'b1;
        @(negedge clk);
        chk(out_spacer(), "R2 spacer after second ack", int'({out_t, out_f}), 0);
        out_ack = 1'b0;
        repeat (2 * N) @(negedge clk);

        // R7: illegal input word
        in_t = 4'b0110;
        in_f = 4'b0011;
        @(negedge clk);
        chk(err == 1'b1, "R7 err raised", int'(err), 1);
        chk(in_ack == 1'b0, "R7 illegal not accepted", int'(in_ack), 0);
        in_t = '0;
        in_f = '0;
        @(negedge clk);
        chk(err == 1'b0, "R7 err cleared", int'(err), 0);
        repeat (N + 2) @(negedge clk);
        chk(out_spacer(), "R7 nothing emitted", int'({out_t, out_f}), 0);

        // R5: incomplete word is not a token
        in_t = 4'b0001;
        in_f = 4'b0100;
        repeat (N + 2) @(negedge clk);
        chk(in_ack == 1'b0 && out_spacer(), "R5 partial word ignored", int'({in_ack, out_t}), 0);
        in_f = 4'b1110;
        @(negedge clk);
        chk(in_ack == 1'b1, "R5 completed word accepted", int'(in_ack), 1);
        in_t = '0;
        in_f = '0;
        lat = 0;
        while (!out_valid() && lat < N + 4) begin
            @(negedge clk);
            lat++;
        end
        chk(out_valid() && out_t == 4'h1, "R5 completed word value", int'(out_t), 1);
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        repeat (2 * N) @(negedge clk);

        // R10 / R3: table-driven stream with gaps and stalls
        rx_en = 1'b1;
        for (int j = 0; j < NV; j++) begin
            repeat (int'(TBL[j][7:4])) @(negedge clk);
            send(TBL[j][11:8]);
        end
        while (rx_idx < NV) @(negedge clk);
        repeat (2 * N) @(negedge clk);
        chk(rx_idx == NV, "R10 no duplicate", rx_idx, NV);
        chk(out_spacer(), "R10 empty after stream", int'({out_t, out_f}), 0);
        rx_en = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule